// File: doc/BRIEF.md
# Single-Register Shift and Arithmetic Unit

This unit performs the one-operand operation group of a small accumulator machine on either an 8-bit or a 16-bit value. Eight operations are offered: add a small amount, subtract a small amount, load a small constant, complement or negate, arithmetic right shift, left shift, and the two rotates that run through the carry bit. Every operation carries a 4-bit constant. For add, subtract and all shifts and rotates the constant means "one less than the amount", so the amount ranges from 1 to 16.

A caller presents the operand, the size select, the operation code, the constant and the incoming carry and overflow flags, and raises `start` for one cycle while `busy` is low. The add, subtract, load and complement operations finish on the accepting edge. Shifts and rotates move one bit position per clock. When an operation finishes, `done` pulses together with the result and four flags: zero, minus, overflow and carry. Register fetch, write-back and instruction decode belong to the surrounding datapath.

Top module: `sru_core`

## Requirements
- R1: After reset `busy`, `done`, `result` and all four flag outputs are 0.
- R2: Increment (op=0) returns operand + constant + 1, modulo the operand size. Carry is the carry out of the add and overflow is signed overflow. `done` is high in the cycle after the accepting edge.
- R3: Decrement (op=1) returns operand − (constant + 1), modulo the size. Carry is set when the subtraction borrows, and overflow is signed overflow.
- R4: Load-constant (op=2) returns the 4-bit constant, zero-extended. The outgoing carry and overflow equal `link_in` and `fault_in`.
- R5: Complement (op=3) with constant 1 returns the two's-complement negation. In that case carry is 1 only for a zero operand, and overflow is 1 only for the most negative value. With any other constant it returns the one's complement, and carry and overflow pass through unchanged.
- R6: Arithmetic right shift (op=4) moves right by constant + 1 places and copies the sign bit into the top each step. Carry is the last bit shifted out, and overflow passes through.
- R7: Left shift (op=5) moves left by constant + 1 places and fills with zeros. Carry is the last bit shifted out, and overflow passes through.
- R8: Rotate right (op=6) and rotate left (op=7) turn by constant + 1 places through a path of size + 1 bits that includes the carry. Overflow passes through.
- R9: With `is_word`=0 the unit uses only `operand[7:0]`, `result[15:8]` is 0, and minus and overflow refer to bit 7. With `is_word`=1 they refer to bit 15.
- R10: On every completion, the zero flag is 1 exactly when the sized result is 0, and the minus flag equals the sized result's top bit.
- R11: A shift or rotate keeps `busy` high for exactly constant + 1 cycles and raises `done` in the cycle after `busy` falls. A `start` while `busy` is high is ignored.
- R12: A `start` in the cycle where `done` is high (with `busy` low) is accepted. A single-cycle operation issued there completes in the very next cycle, so `done` stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request; accepted when busy is low |
| op | input | 3 | Operation code 0..7 (see R2–R8) |
| is_word | input | 1 | 1 selects 16-bit operand, 0 selects 8-bit |
| konst | input | 4 | Constant / amount-minus-one |
| operand | input | 16 | Input value |
| link_in | input | 1 | Incoming carry flag |
| fault_in | input | 1 | Incoming overflow flag |
| busy | output | 1 | Shift or rotate in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 16 | Result, upper byte 0 for byte operations |
| flag_zero | output | 1 | Result is zero |
| flag_minus | output | 1 | Result sign bit |
| flag_fault | output | 1 | Signed overflow |
| flag_link | output | 1 | Carry / last bit shifted out |

## Verification
The two functions that can land in one cycle are a completion strobe and the acceptance of the next request, because `busy` is already low while `done` is high. The bench provokes this in two ways. It issues two requests on consecutive edges, a single-cycle operation followed by another. It also issues a shift followed at once by a second request, which must be dropped because it arrives while `busy` is high. A behavioural model that keeps its own countdown and computes each result in one go is compared against `busy`, `done`, `result` and the flags on every clock. A directed check additionally confirms that the second of two back-to-back single-cycle requests yields a second consecutive `done` carrying its own result.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic [2:0] {
    OP_INC = 3'd0,
    OP_DEC = 3'd1,
    OP_CLR = 3'd2,
    OP_INV = 3'd3,
    OP_ASR = 3'd4,
    OP_SHL = 3'd5,
    OP_ROR = 3'd6,
    OP_ROL = 3'd7
  } sru_op_e;

  // bit 2 of the code marks the iterative (one position per clock) group
  function automatic logic is_iterative(sru_op_e op);
    return op[2];
  endfunction
endpackage

// File: rtl/sru_quick.sv
module sru_quick
  import sru_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int K_W    = 4
) (
  input  sru_op_e           op,
  input  logic              is_word,
  input  logic [K_W-1:0]    konst,
  input  logic [DATA_W-1:0] a,
  input  logic              link_in,
  input  logic              fault_in,
  output logic [DATA_W-1:0] res,
  output logic              link_o,
  output logic              fault_o
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] LO_MASK = {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}};
  localparam logic [DATA_W:0]   ONE_X   = (DATA_W+1)'(1);

  function automatic logic [DATA_W-1:0] fit(logic [DATA_W-1:0] v, logic w);
    return w ? v : (v & LO_MASK);
  endfunction

  function automatic logic top_bit(logic [DATA_W-1:0] v, logic w);
    return w ? v[DATA_W-1] : v[HALF-1];
  endfunction

  function automatic logic [DATA_W-1:0] top_mask(logic w);
    return w ? {1'b1, {(DATA_W-1){1'b0}}}
             : {{(DATA_W-HALF){1'b0}}, 1'b1, {(HALF-1){1'b0}}};
  endfunction

  logic [DATA_W-1:0] a_m;
  logic [DATA_W:0]   amt;
  logic [DATA_W:0]   sum;
  logic [DATA_W:0]   diff;

  always_comb begin
    a_m     = fit(a, is_word);
    amt     = {{(DATA_W+1-K_W){1'b0}}, konst} + ONE_X;
    sum     = {1'b0, a_m} + amt;
    diff    = {1'b0, a_m} - amt;
    res     = a_m;
    link_o  = link_in;
    fault_o = fault_in;
    case (op)
      OP_INC: begin
        res     = fit(sum[DATA_W-1:0], is_word);
        link_o  = is_word ? sum[DATA_W] : sum[HALF];
        fault_o = !top_bit(a_m, is_word) && top_bit(res, is_word);
      end
      OP_DEC: begin
        res     = fit(diff[DATA_W-1:0], is_word);
        link_o  = is_word ? diff[DATA_W] : diff[HALF];
        fault_o = top_bit(a_m, is_word) && !top_bit(res, is_word);
      end
      OP_CLR: res = {{(DATA_W-K_W){1'b0}}, konst};
      OP_INV: begin
        if (konst == K_W'(1)) begin
          res     = fit(~a_m + DATA_W'(1), is_word);
          link_o  = (a_m == '0);
          fault_o = (a_m == top_mask(is_word));
        end else begin
          res = fit(~a_m, is_word);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sru_step.sv
module sru_step
  import sru_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  sru_op_e           op,
  input  logic              is_word,
  input  logic [DATA_W-1:0] val,
  input  logic              link,
  output logic [DATA_W-1:0] val_n,
  output logic              link_n
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] LO_MASK = {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}};

  function automatic logic [DATA_W-1:0] fit(logic [DATA_W-1:0] v, logic w);
    return w ? v : (v & LO_MASK);
  endfunction

  function automatic logic top_bit(logic [DATA_W-1:0] v, logic w);
    return w ? v[DATA_W-1] : v[HALF-1];
  endfunction

  function automatic logic [DATA_W-1:0] top_mask(logic w);
    return w ? {1'b1, {(DATA_W-1){1'b0}}}
             : {{(DATA_W-HALF){1'b0}}, 1'b1, {(HALF-1){1'b0}}};
  endfunction

  always_comb begin
    val_n  = val;
    link_n = link;
    case (op)
      OP_ASR: begin
        val_n  = fit(val >> 1, is_word) | (top_bit(val, is_word) ? top_mask(is_word) : '0);
        link_n = val[0];
      end
      OP_SHL: begin
        val_n  = fit(val << 1, is_word);
        link_n = top_bit(val, is_word);
      end
      OP_ROR: begin
        val_n  = fit(val >> 1, is_word) | (link ? top_mask(is_word) : '0);
        link_n = val[0];
      end
      OP_ROL: begin
        val_n  = fit(val << 1, is_word) | {{(DATA_W-1){1'b0}}, link};
        link_n = top_bit(val, is_word);
      end
      default: ;
    endcase
  end

  // R8: a rotate neither creates nor loses a one across value plus carry
  always_comb begin
    if (!$isunknown({op, is_word, val, link}) && (op == OP_ROR || op == OP_ROL)
        && (is_word || val[DATA_W-1:HALF] == '0)) begin
      p_rotate_keeps_ones_r8: assert ($countones({link_n, val_n}) == $countones({link, val}));
    end
  end
endmodule

// File: rtl/sru_flagcalc.sv
module sru_flagcalc #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] v,
  input  logic              is_word,
  output logic              zero,
  output logic              minus
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    zero  = is_word ? (v == '0) : (v[HALF-1:0] == '0);
    minus = is_word ? v[DATA_W-1] : v[HALF-1];
  end
endmodule

// File: rtl/sru_core.sv
module sru_core
  import sru_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int K_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic              is_word,
  input  logic [K_W-1:0]    konst,
  input  logic [DATA_W-1:0] operand,
  input  logic              link_in,
  input  logic              fault_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              flag_zero,
  output logic              flag_minus,
  output logic              flag_fault,
  output logic              flag_link
);
  localparam int HALF = DATA_W / 2;
  localparam int CNT_W = K_W + 1;
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
  localparam logic [DATA_W-1:0] LO_MASK = {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}};

  sru_op_e op_e;
  assign op_e = sru_op_e'(op);

  // named internal events
  logic accept, accept_iter, last_step;

  logic              busy_q, done_q;
  sru_op_e           wop_q;
  logic              wword_q, wlink_q, wfault_q;
  logic [DATA_W-1:0] work_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] res_q;
  logic              rword_q, zero_q, minus_q, fault_q, link_q;

  logic [DATA_W-1:0] q_res, s_val, fin_res;
  logic              q_link, q_fault, s_link, fin_word, f_zero, f_minus;

  assign accept      = start && !busy_q;
  assign accept_iter = accept && is_iterative(op_e);
  assign last_step   = busy_q && (cnt_q == CNT_ONE);

  sru_quick #(.DATA_W(DATA_W), .K_W(K_W)) u_quick (
    .op(op_e), .is_word(is_word), .konst(konst), .a(operand),
    .link_in(link_in), .fault_in(fault_in),
    .res(q_res), .link_o(q_link), .fault_o(q_fault)
  );

  sru_step #(.DATA_W(DATA_W)) u_step (
    .op(wop_q), .is_word(wword_q), .val(work_q), .link(wlink_q),
    .val_n(s_val), .link_n(s_link)
  );

  assign fin_res  = busy_q ? s_val : q_res;
  assign fin_word = busy_q ? wword_q : is_word;

  sru_flagcalc #(.DATA_W(DATA_W)) u_flags (
    .v(fin_res), .is_word(fin_word), .zero(f_zero), .minus(f_minus)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;  done_q <= 1'b0;  wop_q <= OP_INC;
      wword_q <= 1'b0; wlink_q <= 1'b0; wfault_q <= 1'b0;
      work_q <= '0;    cnt_q <= '0;     res_q <= '0;
      rword_q <= 1'b0; zero_q <= 1'b0;  minus_q <= 1'b0;
      fault_q <= 1'b0; link_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        work_q  <= s_val;
        wlink_q <= s_link;
        cnt_q   <= cnt_q - CNT_ONE;
        if (last_step) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          res_q   <= s_val;
          rword_q <= wword_q;
          link_q  <= s_link;
          fault_q <= wfault_q;
          zero_q  <= f_zero;
          minus_q <= f_minus;
        end
      end else if (accept_iter) begin
        busy_q   <= 1'b1;
        wop_q    <= op_e;
        wword_q  <= is_word;
        work_q   <= is_word ? operand : (operand & LO_MASK);
        wlink_q  <= link_in;
        wfault_q <= fault_in;
        cnt_q    <= {1'b0, konst} + CNT_ONE;
      end else if (accept) begin
        done_q  <= 1'b1;
        res_q   <= q_res;
        rword_q <= is_word;
        link_q  <= q_link;
        fault_q <= q_fault;
        zero_q  <= f_zero;
        minus_q <= f_minus;
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign result     = res_q;
  assign flag_zero  = zero_q;
  assign flag_minus = minus_q;
  assign flag_fault = fault_q;
  assign flag_link  = link_q;

  // window checker for the iterative length
  logic [CNT_W-1:0] chk_len, chk_exp;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_len <= '0;
      chk_exp <= '0;
    end else if (accept_iter) begin
      chk_len <= '0;
      chk_exp <= {1'b0, konst} + CNT_ONE;
    end else if (busy_q) begin
      chk_len <= chk_len + CNT_ONE;
    end
  end

  p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_iter_length_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && chk_len == chk_exp));

  p_single_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op[2]) |=> done);

  p_clear_passes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == 3'd2) |=>
      (result == {{(DATA_W-K_W){1'b0}}, $past(konst)} &&
       flag_link == $past(link_in) && flag_fault == $past(fault_in)));

  p_byte_high_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rword_q) |-> (result[DATA_W-1:HALF] == '0));

  p_zero_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_zero == (result == '0)));
endmodule

// File: tb/test_sru_core.sv
module test_sru_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        is_word = 1'b0;
  logic [3:0]  konst = 4'd0;
  logic [15:0] operand = 16'd0;
  logic        link_in = 1'b0, fault_in = 1'b0;
  logic        busy, done, flag_zero, flag_minus, flag_fault, flag_link;
  logic [15:0] result;

  int checks = 0, failures = 0;
  bit running = 1'b0, finished = 1'b0;

  always #5 clk = ~clk;

  sru_core i_sru_core (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is_word(is_word),
    .konst(konst), .operand(operand), .link_in(link_in), .fault_in(fault_in),
    .busy(busy), .done(done), .result(result), .flag_zero(flag_zero),
    .flag_minus(flag_minus), .flag_fault(flag_fault), .flag_link(flag_link)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(int o);
    case (o)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; default: return "R8";
    endcase
  endfunction

  // behavioural reference: whole result at once, shifts as repeated loops
  task automatic ref_exec(input int o, input bit w, input int k, input int a_in,
                          input bit li, input bit fi,
                          output int r, output bit z, output bit n, output bit f, output bit l);
    int wd, mask, sb, a, v, steps;
    bit nl;
    wd = w ? 16 : 8;
    mask = (1 << wd) - 1;
    sb = 1 << (wd - 1);
    a = a_in & mask;
    steps = k + 1;
    l = li; f = fi; v = a;
    case (o)
      0: begin v = a + steps; l = (v > mask); v &= mask; f = (a < sb) && (v >= sb); end
      1: begin v = a - steps; l = (v < 0); v &= mask; f = (a >= sb) && (v < sb); end
      2: v = k;
      3: if (k == 1) begin v = (-a) & mask; l = (a == 0); f = (a == sb); end
         else v = (~a) & mask;
      4: repeat (steps) begin l = v[0]; v = (v >> 1) | (v & sb); end
      5: repeat (steps) begin l = ((v & sb) != 0); v = (v << 1) & mask; end
      6: repeat (steps) begin nl = v[0]; v = (v >> 1) | (l ? sb : 0); l = nl; end
      default: repeat (steps) begin nl = ((v & sb) != 0); v = ((v << 1) & mask) | int'(l); l = nl; end
    endcase
    r = v; z = (v == 0); n = ((v & sb) != 0);
  endtask

  // cycle model
  bit m_busy = 0, m_done = 0, m_word = 0;
  int m_left = 0, m_op = 0;
  int m_res = 0, p_res = 0;
  bit m_z = 0, m_n = 0, m_f = 0, m_l = 0, p_z = 0, p_n = 0, p_f = 0, p_l = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0;
      m_res = 0; m_z = 0; m_n = 0; m_f = 0; m_l = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1;
          m_res = p_res; m_z = p_z; m_n = p_n; m_f = p_f; m_l = p_l;
        end
      end else if (start) begin
        m_op = op; m_word = is_word;
        ref_exec(op, is_word, konst, operand, link_in, fault_in, p_res, p_z, p_n, p_f, p_l);
        if (op >= 4) begin
          m_busy = 1; m_left = konst + 1;
        end else begin
          m_done = 1;
          m_res = p_res; m_z = p_z; m_n = p_n; m_f = p_f; m_l = p_l;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk(busy == m_busy, "R11", "busy", busy, m_busy);
      chk(done == m_done, (m_op >= 4) ? "R11" : "R2", "done", done, m_done);
      if (m_done && done) begin
        chk(result == m_res[15:0], op_tag(m_op), "result", result, m_res);
        chk(flag_link == m_l, op_tag(m_op), "link", flag_link, m_l);
        chk(flag_fault == m_f, op_tag(m_op), "fault", flag_fault, m_f);
        chk(flag_zero == m_z, "R10", "zero", flag_zero, m_z);
        chk(flag_minus == m_n, m_word ? "R10" : "R9", "minus", flag_minus, m_n);
        if (!m_word) chk(result[15:8] == 8'h00, "R9", "high byte", result[15:8], 0);
      end
    end
  end

  // called at a negedge; returns at the following negedge
  task automatic pulse(int o, bit w, int k, int a, bit li, bit fi);
    start = 1'b1; op = 3'(o); is_word = w; konst = 4'(k);
    operand = 16'(a); link_in = li; fault_in = fi;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(int o, bit w, int k, int a, bit li, bit fi);
    pulse(o, w, k, a, li, fi);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int r; bit z, n, f, l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1", "busy/done", {busy, done}, 0);
    chk(result == 0, "R1", "result", result, 0);
    chk({flag_zero, flag_minus, flag_fault, flag_link} == 0, "R1", "flags",
        {flag_zero, flag_minus, flag_fault, flag_link}, 0);
    running = 1'b1;

    run_op(0, 0, 0, 'h7F, 0, 0);     // R2 signed overflow
    run_op(0, 0, 0, 'hFF, 0, 0);     // R2 carry to zero
    run_op(0, 1, 15, 'hFFF0, 0, 1);  // R2 word wrap
    run_op(1, 0, 0, 'h00, 0, 0);     // R3 borrow
    run_op(1, 1, 0, 'h8000, 0, 0);   // R3 overflow
    run_op(1, 1, 4, 'h0123, 1, 1);   // R3 plain
    run_op(2, 1, 9, 'hBEEF, 1, 1);   // R4 pass-through flags
    run_op(2, 0, 0, 'h55, 0, 1);     // R4 zero result
    run_op(3, 0, 0, 'h55, 1, 0);     // R5 complement
    run_op(3, 0, 1, 'h80, 0, 0);     // R5 negate most negative
    run_op(3, 1, 1, 'h0000, 0, 0);   // R5 negate zero
    run_op(3, 1, 1, 'h0001, 0, 0);   // R5 negate one
    run_op(3, 1, 7, 'h0F0F, 0, 1);   // R5 other constant -> complement
    run_op(4, 0, 2, 'h80, 0, 1);     // R6
    run_op(4, 1, 15, 'h4000, 1, 0);  // R6 full span
    run_op(5, 1, 0, 'h8001, 0, 0);   // R7
    run_op(5, 0, 7, 'h01, 0, 0);     // R7 shifts out to zero
    run_op(6, 0, 0, 'h01, 0, 0);     // R8 ror into carry
    run_op(6, 0, 8, 'hA5, 1, 0);     // R8 nine steps restore
    run_op(7, 1, 15, 'h1234, 1, 0);  // R8 rol word
    run_op(7, 0, 3, 'hAB81, 0, 0);   // R9 high garbage ignored

    // R12: two single-cycle requests on consecutive edges
    pulse(0, 0, 1, 'h10, 0, 0);
    pulse(1, 1, 2, 'h0100, 0, 0);
    ref_exec(1, 1, 2, 'h0100, 0, 0, r, z, n, f, l);
    chk(done == 1'b1, "R12", "second done", done, 1);
    chk(result == r[15:0], "R12", "second result", result, r);
    @(negedge clk);

    // R11: request during a shift is dropped
    pulse(4, 1, 5, 'h8421, 0, 0);
    pulse(2, 0, 3, 'h00, 1, 1);
    while (busy) @(negedge clk);
    @(negedge clk);

    for (int i = 0; i < 300; i++) begin
      int o, k, a;
      o = $urandom_range(0, 7); k = $urandom_range(0, 15); a = $urandom_range(0, 65535);
      if ($urandom_range(0, 3) == 0) begin
        pulse(o, 1'($urandom), k, a, 1'($urandom), 1'($urandom));
        pulse($urandom_range(0, 7), 1'($urandom), $urandom_range(0, 15),
              $urandom_range(0, 65535), 1'($urandom), 1'($urandom));
        while (busy) @(negedge clk);
        @(negedge clk);
      end else begin
        run_op(o, 1'($urandom), k, a, 1'($urandom), 1'($urandom));
      end
    end

    running = 1'b0;
    finish_run();
  end
endmodule